// File: doc/BRIEF.md
# Glitch-Free Two-Input Clock Switch

This block takes two unrelated clocks and forwards exactly one of them to a single output clock. The hand-off never produces a runt pulse. Each input clock comes with three controls: an enable, a select and a skip control.

An input is a candidate only while its enable and its select are both high. When the candidate moves from one clock to the other, the block lets the outgoing clock finish its active phase. It then holds the output at its rest level, and admits the incoming clock only at that clock's next transition to the rest level. Each gating decision is taken by a flip-flop clocked by the clock it gates, so a decision never changes while that clock sits in its active phase.

Two escape paths release the outgoing clock at once instead of at its own edge:
- the skip control of the outgoing input, meant for a clock that has stopped;
- an enable-only change made while both selects are held high.

Parameters choose the clock that drives the output after reset, and whether the output rests low or high.

Top module: `clk_switch`

## Requirements
- R1: While `rst_i` is high the output sits at its rest level. After `rst_i` falls, the output follows the preselected input (`START_ON`, 0 by default) from that clock's next active phase, provided that input is still a candidate.
- R2: An input is a candidate only when both its enable and its select are high. Enable alone or select alone never passes that clock.
- R3: When both inputs are candidates, input 0 drives the output.
- R4: On an ordinary change of candidate, the outgoing clock finishes its current active phase. The output then stays at rest until the incoming clock's next transition to rest, and follows the incoming clock from its next active phase.
- R5: While the outgoing input's skip control is low, a stopped outgoing clock keeps the output at rest indefinitely. Raising that skip control releases it at once, and the incoming clock is then passed after its own next transition to rest.
- R6: With both selects held high, an enable-only change releases the outgoing clock at once, even if that clock has stopped.
- R7: With no candidate, the output stays at its rest level.
- R8: `IDLE_HIGH` = 1 makes the rest level high, in reset and when no input is a candidate. The default of 0 makes it low.
- R9: With the default rest level low, every high output pulse lasts exactly one high phase of one input clock. Every low output interval lasts at least the shorter input half period. The two gates are never open together.
- R10: Raising `rst_i` during operation forces the output to rest immediately and reinstates the preselected input as the open gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk0_i | input | 1 | First input clock |
| clk1_i | input | 1 | Second input clock |
| rst_i | input | 1 | Asynchronous active-high reset |
| en0_i | input | 1 | Enable for input 0 |
| pick0_i | input | 1 | Select for input 0 |
| skip0_i | input | 1 | Release input 0 without waiting for its edge |
| en1_i | input | 1 | Enable for input 1 |
| pick1_i | input | 1 | Select for input 1 |
| skip1_i | input | 1 | Release input 1 without waiting for its edge |
| clk_o | output | 1 | Switched output clock |

## Verification
Suppose a gate flop held the wrong state. Two open gates would OR the clocks, and the first overlap would show a high pulse whose width matches neither input's high phase. A gate stuck closed would leave the output at rest through a whole active phase of the selected clock, which is visible within one period. A gate that released early or late would show up as a truncated pulse or as a missing rest gap between the two clocks. The bench therefore measures every output pulse width. It also samples the output in the middle of each phase of the expected clock, a few cycles after each change of controls.

// File: rtl/cksw_pkg.sv
package cksw_pkg;

    localparam int NUM_CLK = 2;

    typedef struct packed {
        logic en;
        logic pick;
        logic skip;
    } chan_ctl_t;

    typedef enum logic [1:0] {
        OWNER_0    = 2'd0,
        OWNER_1    = 2'd1,
        OWNER_NONE = 2'd2
    } owner_e;

    // Input 0 wins when both are candidates.
    function automatic owner_e resolve(chan_ctl_t c0, chan_ctl_t c1);
        if (c0.en && c0.pick)      return OWNER_0;
        else if (c1.en && c1.pick) return OWNER_1;
        else                       return OWNER_NONE;
    endfunction

    // Immediate release: not wanted, and either skipped or enable-only mode.
    function automatic logic fast_drop(logic wanted, logic skip, logic both_pick);
        return !wanted && (skip || both_pick);
    endfunction

endpackage

// File: rtl/cksw_arbiter.sv
module cksw_arbiter
    import cksw_pkg::*;
(
    input  chan_ctl_t          ctl0_i,
    input  chan_ctl_t          ctl1_i,
    output logic [NUM_CLK-1:0] want_o,
    output logic [NUM_CLK-1:0] drop_o
);

    owner_e owner;
    logic   both_pick;

    always_comb begin
        owner     = resolve(ctl0_i, ctl1_i);
        both_pick = ctl0_i.pick && ctl1_i.pick;
        want_o[0] = (owner == OWNER_0);
        want_o[1] = (owner == OWNER_1);
        drop_o[0] = fast_drop(want_o[0], ctl0_i.skip, both_pick);
        drop_o[1] = fast_drop(want_o[1], ctl1_i.skip, both_pick);
    end

endmodule

// File: rtl/cksw_chan.sv
module cksw_chan #(
    parameter bit IDLE_HIGH  = 1'b0,
    parameter bit START_ON   = 1'b0,
    parameter bit PEER_START = 1'b0,
    parameter int EXTRA_SYNC = 0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic want_i,
    input  logic drop_now_i,
    input  logic peer_on_i,
    output logic on_o
);

    // Decisions are taken when this clock returns to the rest level.
    logic edge_clk;
    logic peer_seen;
    logic on_q;

    assign edge_clk = IDLE_HIGH ? ~clk_i : clk_i;

    generate
        if (EXTRA_SYNC == 0) begin : g_direct
            assign peer_seen = peer_on_i;
        end else begin : g_sync
            logic [EXTRA_SYNC-1:0] stg;
            always_ff @(negedge edge_clk or posedge rst_i) begin
                if (rst_i) begin
                    stg <= {EXTRA_SYNC{PEER_START}};
                end else begin
                    stg[0] <= peer_on_i;
                    for (int k = 1; k < EXTRA_SYNC; k++) begin
                        stg[k] <= stg[k-1];
                    end
                end
            end
            assign peer_seen = stg[EXTRA_SYNC-1];
        end
    endgenerate

    always_ff @(negedge edge_clk or posedge rst_i or posedge drop_now_i) begin
        if (rst_i) begin
            on_q <= START_ON;
        end else if (drop_now_i) begin
            on_q <= 1'b0;
        end else begin
            on_q <= want_i && !peer_seen;
        end
    end

    assign on_o = on_q;

endmodule

// File: rtl/cksw_merge.sv
module cksw_merge
    import cksw_pkg::*;
#(
    parameter bit IDLE_HIGH = 1'b0
) (
    input  logic [NUM_CLK-1:0] clk_i,
    input  logic [NUM_CLK-1:0] on_i,
    input  logic               rst_i,
    output logic               clk_o
);

    logic [NUM_CLK-1:0] active;

    always_comb begin
        active = on_i & (clk_i ^ {NUM_CLK{IDLE_HIGH}});
        if (rst_i) clk_o = IDLE_HIGH;
        else       clk_o = IDLE_HIGH ^ (|active);
    end

endmodule

// File: rtl/clk_switch.sv
module clk_switch
    import cksw_pkg::*;
#(
    parameter int START_ON   = 0,
    parameter bit IDLE_HIGH  = 1'b0,
    parameter int EXTRA_SYNC = 0
) (
    input  logic clk0_i,
    input  logic clk1_i,
    input  logic rst_i,
    input  logic en0_i,
    input  logic pick0_i,
    input  logic skip0_i,
    input  logic en1_i,
    input  logic pick1_i,
    input  logic skip1_i,
    output logic clk_o
);

    chan_ctl_t          ctl0;
    chan_ctl_t          ctl1;
    logic [NUM_CLK-1:0] want_w;
    logic [NUM_CLK-1:0] drop_w;
    logic [NUM_CLK-1:0] on_w;
    logic [NUM_CLK-1:0] clk_w;

    assign ctl0  = '{en: en0_i, pick: pick0_i, skip: skip0_i};
    assign ctl1  = '{en: en1_i, pick: pick1_i, skip: skip1_i};
    assign clk_w = {clk1_i, clk0_i};

    cksw_arbiter u_arb (
        .ctl0_i (ctl0),
        .ctl1_i (ctl1),
        .want_o (want_w),
        .drop_o (drop_w)
    );

    generate
        for (genvar i = 0; i < NUM_CLK; i++) begin : g_chan
            cksw_chan #(
                .IDLE_HIGH  (IDLE_HIGH),
                .START_ON   (START_ON == i),
                .PEER_START (START_ON == (NUM_CLK - 1 - i)),
                .EXTRA_SYNC (EXTRA_SYNC)
            ) u_chan (
                .clk_i      (clk_w[i]),
                .rst_i      (rst_i),
                .want_i     (want_w[i]),
                .drop_now_i (drop_w[i]),
                .peer_on_i  (on_w[NUM_CLK-1-i]),
                .on_o       (on_w[i])
            );
        end
    endgenerate

    cksw_merge #(.IDLE_HIGH(IDLE_HIGH)) u_merge (
        .clk_i (clk_w),
        .on_i  (on_w),
        .rst_i (rst_i),
        .clk_o (clk_o)
    );

endmodule

// File: rtl/cksw_chk.sv
module cksw_chk #(
    parameter bit IDLE_HIGH = 1'b0
) (
    input logic clk0,
    input logic clk1,
    input logic rst,
    input logic en0,
    input logic pick0,
    input logic en1,
    input logic pick1,
    input logic on0,
    input logic on1,
    input logic clk_o
);

    logic e0;
    logic e1;
    assign e0 = clk0 ^ IDLE_HIGH;
    assign e1 = clk1 ^ IDLE_HIGH;

    // R9: the two gates never open together
    p_exclusive_a_r9: assert property (@(posedge clk0) disable iff (rst) !(on0 && on1))
        else $error("two gates open (clock 0 view)");
    p_exclusive_b_r9: assert property (@(posedge clk1) disable iff (rst) !(on0 && on1))
        else $error("two gates open (clock 1 view)");

    // R2: a non-candidate input is closed after its next rest edge
    p_deselect_r2: assert property (@(negedge e0) disable iff (rst)
        !(en0 && pick0) |=> !on0)
        else $error("input 0 open without candidacy");

    // R3: input 1 stays closed while input 0 is also a candidate
    p_priority_r3: assert property (@(negedge e1) disable iff (rst)
        (en0 && pick0 && en1 && pick1) |=> !on1)
        else $error("input 1 opened over input 0");

    // R4: input 1 opens only after input 0 was seen closed
    p_order_r4: assert property (@(negedge e1) disable iff (rst)
        $rose(on1) |-> !$past(on0))
        else $error("input 1 opened before input 0 released");

    // R10: reset holds the output at rest
    p_reset_idle_r10: assert property (@(posedge clk0) rst |-> (clk_o == IDLE_HIGH))
        else $error("output not at rest during reset");

endmodule

bind clk_switch cksw_chk #(.IDLE_HIGH(IDLE_HIGH)) u_chk (
    .clk0  (clk0_i),
    .clk1  (clk1_i),
    .rst   (rst_i),
    .en0   (en0_i),
    .pick0 (pick0_i),
    .en1   (en1_i),
    .pick1 (pick1_i),
    .on0   (on_w[0]),
    .on1   (on_w[1]),
    .clk_o (clk_o)
);

// File: tb/clk_switch_test.sv
`timescale 1ns/1ps
module clk_switch_test;

    logic c0 = 1'b0, c1 = 1'b0, rst = 1'b1;
    logic run0 = 1'b1, run1 = 1'b1;
    logic en0 = 1'b1, pk0 = 1'b1, sk0 = 1'b0;
    logic en1 = 1'b0, pk1 = 1'b0, sk1 = 1'b0;
    logic out, out_hi;

    int checks = 0, errors = 0, n1f = 0, cur = 0, bad_pulse = 0;
    bit mon_en = 1'b0, armed = 1'b0, done = 1'b0;
    realtime last_t = 0.0;

    clk_switch uut (
        .clk0_i(c0), .clk1_i(c1), .rst_i(rst),
        .en0_i(en0), .pick0_i(pk0), .skip0_i(sk0),
        .en1_i(en1), .pick1_i(pk1), .skip1_i(sk1),
        .clk_o(out)
    );

    clk_switch #(.START_ON(1), .IDLE_HIGH(1'b1)) uut_hi (
        .clk0_i(c0), .clk1_i(c1), .rst_i(rst),
        .en0_i(en0), .pick0_i(pk0), .skip0_i(sk0),
        .en1_i(en1), .pick1_i(pk1), .skip1_i(sk1),
        .clk_o(out_hi)
    );

    // 200 MHz input 0; 7 ns input 1, offset so that edges never coincide.
    // A stopped clock always parks low.
    initial forever begin
        #2.5;
        if (run0 || c0) c0 = ~c0;
    end
    initial begin
        #1.3;
        forever begin
            #3.5;
            if (run1 || c1) c1 = ~c1;
        end
    end

    always @(negedge c1) n1f++;

    // Pulse-width monitor for R9
    always @(out) begin
        realtime w;
        w = $realtime - last_t;
        if (mon_en && armed) begin
            if (out == 1'b0) begin
                if (!((w > 2.49 && w < 2.51) || (w > 3.49 && w < 3.51))) bad_pulse++;
            end else if (w < 2.49) begin
                bad_pulse++;
            end
        end
        armed  = mon_en;
        last_t = $realtime;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_owner(bit e0, bit p0, bit e1, bit p1);
        if (e0 && p0) return 0;
        if (e1 && p1) return 1;
        return 2;
    endfunction

    task automatic follows(input int ch, input string req);
        bit ok = 1'b1;
        repeat (3) begin
            if (ch == 0) @(posedge c0); else @(posedge c1);
            #0.5;
            if (out !== 1'b1) ok = 1'b0;
            if (ch == 0) @(negedge c0); else @(negedge c1);
            #0.5;
            if (out !== 1'b0) ok = 1'b0;
        end
        chk(ok, req, "output follows expected clock", int'(ok), 1);
    endtask

    task automatic stays_idle(input string req);
        bit ok = 1'b1, ok_hi = 1'b1;
        repeat (40) begin
            #0.7;
            if (out !== 1'b0) ok = 1'b0;
            if (out_hi !== 1'b1) ok_hi = 1'b0;
        end
        chk(ok, req, "low-rest output stays low", int'(ok), 1);
        chk(ok_hi, "R8", "high-rest output stays high", int'(ok_hi), 1);
    endtask

    task automatic set_ctl(input bit a0, input bit b0, input bit k0,
                           input bit a1, input bit b1, input bit k1);
        en0 = a0; pk0 = b0; sk0 = k0;
        en1 = a1; pk1 = b1; sk1 = k1;
    endtask

    // Change controls while the currently passed clock is low
    task automatic go_ctl(input bit a0, input bit b0, input bit k0,
                          input bit a1, input bit b1, input bit k1);
        if (cur == 0) begin @(negedge c0); #0.2; end
        else if (cur == 1) begin @(negedge c1); #0.2; end
        set_ctl(a0, b0, k0, a1, b1, k1);
        cur = exp_owner(a0, b0, a1, b1);
    endtask

    task automatic expect_cur(input string req);
        if (cur == 2) stays_idle(req);
        else follows(cur, req);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int start;
        bit ok;
        void'($urandom(32'd2024));

        // R1 / R8: reset state
        #12;
        chk(out === 1'b0, "R1", "low-rest output in reset", int'(out), 0);
        chk(out_hi === 1'b1, "R8", "high-rest output in reset", int'(out_hi), 1);
        @(negedge c0); #0.3;
        rst = 1'b0;
        mon_en = 1'b1;
        follows(0, "R1");

        // R2 / R7: partial controls select nothing
        go_ctl(0, 1, 0, 1, 0, 0); #45; stays_idle("R2");
        go_ctl(1, 0, 0, 0, 1, 0); #45; stays_idle("R7");
        go_ctl(0, 0, 0, 1, 1, 0); #45; follows(1, "R2");
        go_ctl(1, 1, 0, 0, 0, 0); #45; follows(0, "R2");

        // R4: ordered handover from input 0 to input 1
        @(posedge c0); #0.5;
        set_ctl(1, 0, 0, 1, 1, 0);
        #0.3;
        chk(out === 1'b1, "R4", "old high phase completes", int'(out), 1);
        @(negedge c0); #0.05;
        start = n1f;
        ok = 1'b1;
        while (n1f == start) begin
            if (out !== 1'b0) ok = 1'b0;
            #0.1;
        end
        chk(ok, "R4", "rest gap until new falling edge", int'(ok), 1);
        @(posedge c1); #0.5;
        chk(out === 1'b1, "R4", "new clock passed", int'(out), 1);
        cur = 1;

        // R5: stopped outgoing clock, skip control
        go_ctl(1, 1, 0, 0, 0, 0); #45;
        run0 = 1'b0; #12;
        set_ctl(1, 0, 0, 1, 1, 0);
        ok = 1'b1;
        repeat (50) begin #0.8; if (out !== 1'b0) ok = 1'b0; end
        chk(ok, "R5", "stopped clock holds output without skip", int'(ok), 1);
        sk0 = 1'b1; #30;
        follows(1, "R5");
        cur = 1; sk0 = 1'b0; run0 = 1'b1; #20;

        // R6: enable-only change with stopped outgoing clock
        go_ctl(1, 1, 0, 0, 0, 0); #45;
        run0 = 1'b0; #12;
        set_ctl(0, 1, 0, 1, 1, 0);
        #30;
        follows(1, "R6");
        cur = 1; run0 = 1'b1; #20;

        // R3: both candidates
        go_ctl(1, 1, 0, 1, 1, 0); #45; follows(0, "R3");

        // Random control patterns (R2, R3, R7)
        for (int i = 0; i < 16; i++) begin
            logic [31:0] r;
            r = $urandom;
            go_ctl(r[0], r[1], 1'b0, r[2], r[3], 1'b0);
            #45;
            expect_cur("R2");
        end

        // R10: reset during operation on input 1
        go_ctl(0, 0, 0, 1, 1, 0); #45; follows(1, "R10");
        @(negedge c1); #0.2;
        mon_en = 1'b0;
        rst = 1'b1; #0.5;
        chk(out === 1'b0, "R10", "output at rest on reset", int'(out), 0);
        set_ctl(1, 1, 0, 0, 0, 0);
        #10;
        @(negedge c0); #0.3;
        rst = 1'b0; cur = 0;
        mon_en = 1'b1;
        @(posedge c0); #0.5;
        chk(out === 1'b1, "R10", "input 0 passed at once", int'(out), 1);
        follows(0, "R10");

        chk(bad_pulse == 0, "R9", "pulse widths", bad_pulse, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule